// File: doc/BRIEF.md
# Dual-Channel Storage Host Register File

This block is the register file of a two-channel serial storage host controller. A host reaches it through a byte-addressed register bus. The bus has read and write strobes, a two-bit access size (0 byte, 1 halfword, 2 word) and a 9-bit address. Read data is combinational: it is valid in the same cycle as the read strobe. Writes take effect at the next rising clock edge.

For each channel the block holds the following registers:
- a bus-master DMA command register;
- a DMA status register;
- a 32-bit descriptor pointer;
- a 6-bit scratch byte;
- a configuration/status word, which carries the channel interrupt-pending flag;
- a 12-bit link control register, which can fire a channel reset;
- an interrupt-enable mask.

Two summary words pack the command, interrupt and status bits of both channels into one read. A single interrupt output is raised whenever either channel has an interrupt pending.

Taskfile accesses to the attached drive are not decoded here. They are passed out on a plain forwarding port, and the read data comes back on a matching input. The DMA engine and the link layer sit outside this block. They feed the block through the active, error and done inputs and through the interrupt inputs.

Top module: `stor2ch_regfile`

## Requirements
- R1: Channel 0 registers sit at these offsets: command 0x00, scratch 0x01, status 0x02, descriptor pointer 0x04-0x07. Channel 1 uses 0x08, 0x09, 0x0A and 0x0C-0x0F for the same registers. The command register keeps only bits 0 and 3 of a write, and its bit 0 drives that channel's `dma_start` output. Offsets 0x03 and 0x0B read as zero.
- R2: Writes to 0x10/0x11/0x12 behave exactly like writes to 0x00/0x01/0x02. Writes to 0x18/0x19/0x1A behave exactly like writes to 0x08/0x09/0x0A.
- R3: The scratch byte keeps only bits 5:0 of the written byte. Bits 7:6 always read 0.
- R4: The status register has these bits:
  - bit 0 shows the channel's `dma_active` input, and writes do not change it;
  - bit 1 is set by a `dma_err_set` pulse and bit 2 by a `dma_done_set` pulse; writing 1 clears either bit and writing 0 leaves it; in a cycle with both an event and a write, the event wins;
  - bits 5 and 6 take the written value;
  - all other bits read 0.
- R5: A read at 0x10 returns the following:
  - channel 0 command in the low bits;
  - bit 4 = channel 0 interrupt flag;
  - bit 6 = channel 1 interrupt flag;
  - bit 14 = channel 1 status bit 2;
  - bits 23:16 = channel 0 status;
  - bits 31:24 = channel 1 status.
- R6: A read at 0x18 returns channel 1 command, with bit 4 = channel 1 interrupt flag and bits 23:16 = channel 1 status.
- R7: The configuration/status words are at 0xA0 (channel 0) and 0xE0 (channel 1). Each resets to 0x6515_0000. Bit 11 of each word follows that channel's `dev_irq` input one clock later.
- R8: `irq` is high exactly when bit 11 of either configuration/status word is set.
- R9: Link control is at 0x100 (channel 0) and 0x180 (channel 1). It stores bits 11:0 of a write. If bit 0 of the written value is 1, `chan_reset` for that channel is high for exactly the one cycle after the write edge.
- R10: The interrupt-enable mask is at 0x148 (channel 0) and 0x1C8 (channel 1). It takes write bits 31:16 ANDed with 0x3EED, and reads return it in bits 31:16.
- R11: Link status at 0x104 (channel 0) and 0x184 (channel 1) reads 0x113 when that channel's `dev_present` bit is high and 0 otherwise. Every unmapped address reads 0.
- R12: The taskfile windows are 0x80-0x87 (channel 0) and 0xC0-0xC7 (channel 1). A byte access in these windows, or an access of any size at the window's offset 0, is forwarded: `tf_valid` is raised, `tf_chan` = address bit 6 and `tf_reg` = address bits 2:0, and reads return `tf_rdata`. A wider access at any other window offset is not forwarded and reads as all ones for its size.
- R13: Read data is masked to the access size. A descriptor-pointer access at byte offset k reads the pointer shifted right by 8k. A write of n bytes at offset k replaces pointer bytes k..k+n-1, taken from the low bytes of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data, low-aligned |
| bus_rdata | output | 32 | Read data, combinational |
| dev_irq | input | 2 | Per-channel interrupt level from the device side |
| dev_present | input | 2 | Per-channel device-present indication |
| dma_active | input | 2 | Per-channel DMA engine busy |
| dma_err_set | input | 2 | Per-channel DMA error event pulse |
| dma_done_set | input | 2 | Per-channel DMA interrupt event pulse |
| dma_start | output | 2 | Per-channel command start bit |
| chan_reset | output | 2 | Per-channel one-cycle reset pulse |
| irq | output | 1 | Combined interrupt |
| tf_valid | output | 1 | Taskfile access forwarded this cycle |
| tf_write | output | 1 | Forwarded access is a write |
| tf_chan | output | 1 | Forwarded channel |
| tf_reg | output | 3 | Forwarded taskfile register index |
| tf_size | output | 2 | Forwarded access size |
| tf_wdata | output | 32 | Forwarded write data |
| tf_rdata | input | 32 | Taskfile read data |

## Verification
The checker watches these properties on every cycle:
- the one-cycle lag from `dev_irq` to `irq`;
- that a channel reset pulse always follows a link-control write with bit 0 set;
- the fixed reset pattern in the upper half of each configuration word;
- the zero bits of scratch reads, reserved offsets and link status;
- that the taskfile port is only driven for forwardable accesses.

Other behaviour needs the bench's ordered scenarios:
- the write-one-to-clear, direct-write and read-only mix in the status register;
- the alias writes;
- the exact packing of both summary words;
- byte-lane updates of the descriptor pointer;
- the all-ones result of a wide taskfile access that is not forwarded.

// File: rtl/stor2ch_pkg.sv
package stor2ch_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;
    localparam int NBYTE  = DATA_W / 8;
    localparam int BOFF_W = $clog2(NBYTE);
    localparam int LCTL_W = 12;
    localparam int MASK_W = 16;
    localparam int SCR_W  = 6;
    localparam int INT_BIT = 11;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [DATA_W-1:0] CONF_RST  = 32'h6515_0000;
    localparam logic [DATA_W-1:0] LSTAT_UP  = 32'h0000_0113;
    localparam logic [7:0]        CMD_KEEP  = 8'h09;
    localparam logic [7:0]        STAT_W1C  = 8'h06;
    localparam logic [7:0]        STAT_RW   = 8'h60;
    localparam logic [MASK_W-1:0] MASK_KEEP = 16'h3EED;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CMD, SEL_SCR, SEL_STAT, SEL_PTR, SEL_LCTL, SEL_MASK
    } wsel_e;

    typedef struct packed {
        logic  ch;
        wsel_e sel;
    } wdec_t;

    typedef struct packed {
        logic [7:0]        cmd;
        logic [SCR_W-1:0]  scr;
        logic [7:0]        stat;
        logic [DATA_W-1:0] ptr;
        logic [DATA_W-1:0] conf;
        logic [LCTL_W-1:0] lctl;
        logic [MASK_W-1:0] mask;
    } chan_view_t;

    function automatic wdec_t decode_wr(input logic [ADDR_W-1:0] a);
        wdec_t d;
        d.ch  = 1'b0;
        d.sel = SEL_NONE;
        if (a[8:5] == 4'b0000) begin
            d.ch = a[3];
            if (a[2]) begin
                if (!a[4]) d.sel = SEL_PTR;
            end else begin
                case (a[1:0])
                    2'd0:    d.sel = SEL_CMD;
                    2'd1:    d.sel = SEL_SCR;
                    2'd2:    d.sel = SEL_STAT;
                    default: d.sel = SEL_NONE;
                endcase
            end
        end else if (a[8] && a[6:0] == 7'h00) begin
            d.ch  = a[7];
            d.sel = SEL_LCTL;
        end else if (a[8] && a[6:0] == 7'h48) begin
            d.ch  = a[7];
            d.sel = SEL_MASK;
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] stat_update(input logic [7:0] old, input logic [7:0] w);
        return (old & STAT_W1C & ~w) | (w & STAT_RW);
    endfunction
endpackage

// File: rtl/stor2ch_chan.sv
module stor2ch_chan
    import stor2ch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  wsel_e             sel,
    input  logic [BOFF_W-1:0] boff,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_in,
    input  logic              active,
    input  logic              err_set,
    input  logic              done_set,
    output chan_view_t        view,
    output logic              rst_pulse,
    output logic              dma_start
);
    localparam int NB_W = BOFF_W + 2;

    logic [7:0]        cmd_q;
    logic [SCR_W-1:0]  scr_q;
    logic [7:0]        stat_q;
    logic [DATA_W-1:0] ptr_q;
    logic              flag_q;
    logic [LCTL_W-1:0] lctl_q;
    logic [MASK_W-1:0] mask_q;
    logic [7:0]        events;
    logic [DATA_W-1:0] wshift;
    logic [NB_W-1:0]   nbytes;

    assign events = {5'b0, done_set, err_set, 1'b0};
    assign wshift = wdata << (8 * boff);
    assign nbytes = NB_W'(1) << size;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            scr_q     <= '0;
            stat_q    <= '0;
            flag_q    <= 1'b0;
            lctl_q    <= '0;
            mask_q    <= '0;
            rst_pulse <= 1'b0;
        end else begin
            flag_q    <= irq_in;
            rst_pulse <= we && sel == SEL_LCTL && wdata[0];
            if (we && sel == SEL_STAT) stat_q <= stat_update(stat_q, wdata[7:0]) | events;
            else                       stat_q <= stat_q | events;
            if (we && sel == SEL_CMD)  cmd_q  <= wdata[7:0] & CMD_KEEP;
            if (we && sel == SEL_SCR)  scr_q  <= wdata[SCR_W-1:0];
            if (we && sel == SEL_LCTL) lctl_q <= wdata[LCTL_W-1:0];
            if (we && sel == SEL_MASK) mask_q <= wdata[DATA_W-1:DATA_W-MASK_W] & MASK_KEEP;
        end
    end

    for (genvar i = 0; i < NBYTE; i++) begin : g_lane
        logic lane_en;
        assign lane_en = (NB_W'(i) >= NB_W'(boff)) && (NB_W'(i) < NB_W'(boff) + nbytes);
        always_ff @(posedge clk) begin
            if (rst)                               ptr_q[8*i +: 8] <= '0;
            else if (we && sel == SEL_PTR && lane_en) ptr_q[8*i +: 8] <= wshift[8*i +: 8];
        end
    end

    always_comb begin
        view.cmd  = cmd_q;
        view.scr  = scr_q;
        view.stat = stat_q | {7'b0, active};
        view.ptr  = ptr_q;
        view.conf = CONF_RST | (DATA_W'(flag_q) << INT_BIT);
        view.lctl = lctl_q;
        view.mask = mask_q;
    end

    assign dma_start = cmd_q[0];
endmodule

// File: rtl/stor2ch_rdmux.sv
module stor2ch_rdmux
    import stor2ch_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  chan_view_t        views [NCH],
    input  logic [NCH-1:0]    present,
    input  logic              tf_region,
    input  logic              tf_fwd,
    input  logic [DATA_W-1:0] tf_rdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] raw;
    logic              f0, f1;

    assign f0 = views[0].conf[INT_BIT];
    assign f1 = views[1].conf[INT_BIT];

    always_comb begin
        raw = '0;
        if (tf_region) begin
            raw = tf_fwd ? tf_rdata : '1;
        end else if (addr[8:4] == 5'b00000) begin
            if (addr[2]) begin
                raw = views[addr[3]].ptr >> (8 * addr[1:0]);
            end else begin
                case (addr[1:0])
                    2'd0:    raw = DATA_W'(views[addr[3]].cmd);
                    2'd1:    raw = DATA_W'(views[addr[3]].scr);
                    2'd2:    raw = DATA_W'(views[addr[3]].stat);
                    default: raw = '0;
                endcase
            end
        end else if (addr == 9'h010) begin
            raw = DATA_W'(views[0].cmd) | (DATA_W'(f0) << 4) | (DATA_W'(f1) << 6)
                | (DATA_W'(views[1].stat[2]) << 14)
                | (DATA_W'(views[0].stat) << 16) | (DATA_W'(views[1].stat) << 24);
        end else if (addr == 9'h018) begin
            raw = DATA_W'(views[1].cmd) | (DATA_W'(f1) << 4)
                | (DATA_W'(views[1].stat) << 16);
        end else if (!addr[8] && addr[7] && addr[5] && addr[4:0] == 5'b0) begin
            raw = views[addr[6]].conf;
        end else if (addr[8] && addr[6:0] == 7'h00) begin
            raw = DATA_W'(views[addr[7]].lctl);
        end else if (addr[8] && addr[6:0] == 7'h04) begin
            raw = present[addr[7]] ? LSTAT_UP : '0;
        end else if (addr[8] && addr[6:0] == 7'h48) begin
            raw = {views[addr[7]].mask, {(DATA_W-MASK_W){1'b0}}};
        end
        rdata = raw & size_mask(size);
    end
endmodule

// File: rtl/stor2ch_regfile.sv
module stor2ch_regfile
    import stor2ch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [1:0]          bus_size,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NCH-1:0]      dev_irq,
    input  logic [NCH-1:0]      dev_present,
    input  logic [NCH-1:0]      dma_active,
    input  logic [NCH-1:0]      dma_err_set,
    input  logic [NCH-1:0]      dma_done_set,
    output logic [NCH-1:0]      dma_start,
    output logic [NCH-1:0]      chan_reset,
    output logic                irq,
    output logic                tf_valid,
    output logic                tf_write,
    output logic                tf_chan,
    output logic [2:0]          tf_reg,
    output logic [1:0]          tf_size,
    output logic [DATA_W-1:0]   tf_wdata,
    input  logic [DATA_W-1:0]   tf_rdata
);
    wdec_t      dec;
    chan_view_t views [NCH];
    logic [NCH-1:0] flags;
    logic       tf_region;
    logic       tf_fwd;

    assign dec = decode_wr(bus_addr);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        stor2ch_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .we        (bus_wr && dec.ch == c[0]),
            .sel       (dec.sel),
            .boff      (bus_addr[BOFF_W-1:0]),
            .size      (bus_size),
            .wdata     (bus_wdata),
            .irq_in    (dev_irq[c]),
            .active    (dma_active[c]),
            .err_set   (dma_err_set[c]),
            .done_set  (dma_done_set[c]),
            .view      (views[c]),
            .rst_pulse (chan_reset[c]),
            .dma_start (dma_start[c])
        );
        assign flags[c] = views[c].conf[INT_BIT];
    end

    assign irq = |flags;

    assign tf_region = !bus_addr[8] && bus_addr[7] && bus_addr[5:3] == 3'b000;
    assign tf_fwd    = tf_region && (bus_size == SZ_BYTE || bus_addr[2:0] == 3'b000);
    assign tf_valid  = tf_fwd && (bus_rd || bus_wr);
    assign tf_write  = bus_wr;
    assign tf_chan   = bus_addr[6];
    assign tf_reg    = bus_addr[2:0];
    assign tf_size   = bus_size;
    assign tf_wdata  = bus_wdata;

    stor2ch_rdmux u_rdmux (
        .addr      (bus_addr),
        .size      (bus_size),
        .views     (views),
        .present   (dev_present),
        .tf_region (tf_region),
        .tf_fwd    (tf_fwd),
        .tf_rdata  (tf_rdata),
        .rdata     (bus_rdata)
    );
endmodule

// File: rtl/stor2ch_checker.sv
module stor2ch_checker
    import stor2ch_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [1:0]        bus_size,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NCH-1:0]    dev_irq,
    input logic [NCH-1:0]    dev_present,
    input logic [NCH-1:0]    chan_reset,
    input logic              irq,
    input logic              tf_valid,
    input logic [2:0]        tf_reg
);
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        dev_irq != '0 |=> irq); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        dev_irq == '0 |=> !irq); // R8
    AST_RESET_CAUSE0: assert property (@(posedge clk) disable iff (rst)
        chan_reset[0] |-> $past(bus_wr && bus_addr == 9'h100 && bus_wdata[0])); // R9
    AST_RESET_CAUSE1: assert property (@(posedge clk) disable iff (rst)
        chan_reset[1] |-> $past(bus_wr && bus_addr == 9'h180 && bus_wdata[0])); // R9
    AST_CONF_PATTERN: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (bus_addr == 9'h0A0 || bus_addr == 9'h0E0) && bus_size == SZ_WORD
        |-> bus_rdata[31:16] == 16'h6515); // R7
    AST_SCRATCH_NARROW: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (bus_addr == 9'h001 || bus_addr == 9'h009) |-> bus_rdata[7:6] == 2'b00); // R3
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd && (bus_addr == 9'h003 || bus_addr == 9'h00B) |-> bus_rdata == '0); // R1
    AST_LINK_STATUS: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_addr == 9'h104 && bus_size == SZ_WORD
        |-> bus_rdata == (dev_present[0] ? LSTAT_UP : '0)); // R11
    AST_TF_FORWARD: assert property (@(posedge clk) disable iff (rst)
        tf_valid |-> (bus_size == SZ_BYTE || tf_reg == 3'd0)); // R12
endmodule

bind stor2ch_regfile stor2ch_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_size    (bus_size),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dev_irq     (dev_irq),
    .dev_present (dev_present),
    .chan_reset  (chan_reset),
    .irq         (irq),
    .tf_valid    (tf_valid),
    .tf_reg      (tf_reg)
);

// File: tb/test_stor2ch_regfile.sv
module test_stor2ch_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  dev_irq = '0, dev_present = '0, dma_active = '0;
    logic [1:0]  dma_err_set = '0, dma_done_set = '0;
    logic [1:0]  dma_start, chan_reset;
    logic        irq, tf_valid, tf_write, tf_chan;
    logic [2:0]  tf_reg;
    logic [1:0]  tf_size;
    logic [31:0] tf_wdata;
    logic [31:0] tf_rdata = 32'hDEAD_BEEF;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] q_exp [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    stor2ch_regfile i_stor2ch_regfile (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (bus_rd) begin
            if (q_exp.size() == 0) check("monitor-empty", bus_rdata, 32'hx);
            else check(q_tag.pop_front(), bus_rdata, q_exp.pop_front());
        end
    end

    task automatic wr(input logic [8:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [1:0] sz, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        q_exp.push_back(e); q_tag.push_back(tag);
        bus_rd = 1; bus_addr = a; bus_size = sz;
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic rd_tf(input logic [8:0] a, input logic [1:0] sz, input logic [31:0] e,
                         input logic v, input logic ch, input logic [2:0] r, input string tag);
        @(posedge clk); #1;
        q_exp.push_back(e); q_tag.push_back(tag);
        bus_rd = 1; bus_addr = a; bus_size = sz;
        @(negedge clk);
        check({tag, " tf_valid"}, 32'(tf_valid), 32'(v));
        if (v) begin
            check({tag, " tf_chan"}, 32'(tf_chan), 32'(ch));
            check({tag, " tf_reg"}, 32'(tf_reg), 32'(r));
        end
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check("R8 irq after reset", 32'(irq), 0);
        check("R9 chan_reset after reset", 32'(chan_reset), 0);
        rd(9'h0A0, 2, 32'h6515_0000, "R7 conf0 reset");
        rd(9'h0E0, 2, 32'h6515_0000, "R7 conf1 reset");

        wr(9'h000, 0, 32'hFF);
        rd(9'h000, 0, 32'h09, "R1 cmd0 keeps bits 0,3");
        check("R1 dma_start", 32'(dma_start), 32'h1);
        wr(9'h011, 0, 32'hFF);
        rd(9'h001, 0, 32'h3F, "R2 R3 scratch0 via alias");
        wr(9'h009, 0, 32'hC5);
        rd(9'h009, 0, 32'h05, "R3 scratch1");
        rd(9'h003, 0, 32'h0, "R1 offset 3 zero");
        rd(9'h00B, 0, 32'h0, "R1 offset B zero");

        wr(9'h004, 2, 32'h1234_5678);
        rd(9'h004, 2, 32'h1234_5678, "R13 ptr0 word");
        wr(9'h006, 0, 32'hAB);
        rd(9'h004, 2, 32'h12AB_5678, "R13 ptr0 byte lane");
        rd(9'h007, 0, 32'h12, "R13 ptr0 byte read");
        rd(9'h00C, 2, 32'h0, "R1 ptr1 untouched");

        @(posedge clk); #1 dma_err_set = 2'b01; dma_done_set = 2'b01; dma_active = 2'b01;
        @(posedge clk); #1 dma_err_set = 0; dma_done_set = 0;
        rd(9'h002, 0, 32'h07, "R4 status events and active");
        wr(9'h002, 0, 32'hE2);
        rd(9'h002, 0, 32'h65, "R4 w1c bit1, rw bits 5,6");
        wr(9'h012, 0, 32'h04);
        rd(9'h002, 0, 32'h01, "R2 R4 alias clears bit2");

        @(posedge clk); #1 dma_done_set = 2'b10; dev_irq = 2'b10;
        @(posedge clk); #1 dma_done_set = 0;
        @(negedge clk);
        check("R8 irq from ch1", 32'(irq), 1);
        rd(9'h010, 2, 32'h0401_4049, "R5 summary 0x10");
        wr(9'h018, 0, 32'h01);
        rd(9'h018, 2, 32'h0004_0011, "R6 summary 0x18");
        rd(9'h0E0, 2, 32'h6515_0800, "R7 conf1 flag");
        rd(9'h010, 0, 32'h49, "R13 size mask byte");
        @(posedge clk); #1 dev_irq = 0;
        @(posedge clk);
        @(negedge clk);
        check("R8 irq clears", 32'(irq), 0);

        wr(9'h100, 2, 32'hFFFF_F001);
        check("R9 reset pulse ch0", 32'(chan_reset), 32'h1);
        @(posedge clk); #1;
        check("R9 pulse one cycle", 32'(chan_reset), 0);
        rd(9'h100, 2, 32'h001, "R9 lctl0 12 bits");
        wr(9'h180, 2, 32'h0AA);
        check("R9 no pulse for bit0=0", 32'(chan_reset), 0);
        rd(9'h180, 2, 32'h0AA, "R9 lctl1");

        wr(9'h148, 2, 32'hFFFF_1234);
        rd(9'h148, 2, 32'h3EED_0000, "R10 mask0");
        rd(9'h1C8, 2, 32'h0, "R10 mask1 untouched");

        @(posedge clk); #1 dev_present = 2'b01;
        rd(9'h104, 2, 32'h113, "R11 link up");
        rd(9'h184, 2, 32'h0, "R11 link down");
        rd(9'h1F0, 2, 32'h0, "R11 unmapped");

        rd_tf(9'h083, 0, 32'hEF, 1, 0, 3, "R12 byte tf ch0");
        rd_tf(9'h0C0, 2, 32'hDEAD_BEEF, 1, 1, 0, "R12 word data ch1");
        rd_tf(9'h082, 1, 32'hFFFF, 0, 0, 0, "R12 wide non-data");

        repeat (2) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule